// File: doc/BRIEF.md
# Buffer Descriptor Ring Controller

This block owns a single table of two-word buffer descriptors and divides it into a transmit ring and a receive ring at a boundary that software programs. Each descriptor has a control word and a buffer address word. The control word holds the frame length in bits 31:16 and ownership, interrupt, wrap and status flags in the low half. Software reads and writes the table, the boundary, a mode register and a frame-length register. The block tracks the descriptor each ring is working on, decides when a transmit may start and writes status back when a frame finishes.

Frame data does not pass through the block. A transmit appears as a one-cycle `tx_start` carrying the length and buffer address. The data mover answers with `tx_done`. A received frame arrives as a one-cycle `rx_req` carrying its length and an address-filter miss flag. Three one-cycle event pulses (transmit done, receive done, receive dropped) feed an external interrupt-status register.

The host register map is selected by `reg_sel`: 0 is mode, 1 is boundary, 2 is frame length, and 3 reads zero. In the mode register, bit 0 enables receive, bit 1 enables transmit and bit 2 enables huge frames. The frame-length register holds the minimum length in bits 31:16 and the maximum in bits 15:0. In a control word, bit 15 is ready/empty, bit 14 requests an event, bit 13 is wrap, bit 12 requests padding and bit 7 is the receive miss flag.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After reset, the boundary reads NDESC/2 and the frame-length register reads 0x00400600. The mode register reads 0 and no event or start is active. The transmit ring points at descriptor 0 and the receive ring points at descriptor NDESC/2.
- R2: A boundary write with a value of NDESC or more leaves the boundary unchanged. Smaller values are stored.
- R3: When the receive enable turns on, the receive index is set to the boundary. When the transmit enable turns on, the transmit index is set to 0.
- R4: `tx_start` is high for exactly one cycle when all of the following hold: transmit is enabled, the boundary is non-zero, the current descriptor has bit 15 set, its length is above 4, and no transmit is in progress.
- R5: `tx_len` is raised to the minimum length when bit 12 is set and the length is below the minimum. It is then cut to the maximum unless huge-frame mode is on.
- R6: On `tx_done` during a transmit, the descriptor's bits 15 and 8:0 are cleared. All other bits are kept.
- R7: After a transmit, the transmit index goes to 0 if bit 13 was set. Otherwise it increments, and it becomes 0 when the incremented value reaches the boundary.
- R8: `ev_txb` pulses the cycle after a completed transmit whose descriptor had bit 14 set, and only then.
- R9: A receive on a descriptor with bit 15 clear leaves the descriptor and the index unchanged and pulses `ev_busy`.
- R10: A receive on a descriptor with bit 15 set writes `rx_len` to bits 31:16 and clears bits 15 and 8:0. It sets bit 7 if `rx_miss` is set and keeps bits 14:9.
- R11: After a receive, the receive index returns to the boundary if bit 13 was set or the index was NDESC-1. Otherwise it increments.
- R12: `ev_rxb` pulses the cycle after a completed receive whose descriptor had bit 14 set.
- R13: `rx_req` while receive is disabled, and `tx_done` while no transmit is in progress, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| dt_we | input | 1 | Descriptor-table write strobe |
| dt_addr | input | $clog2(NDESC)+1 | Word address: byte address bits $clog2(NDESC)+2:2; the low bit selects the address word |
| dt_wdata | input | 32 | Descriptor write data |
| dt_rdata | output | 32 | Descriptor read data |
| tx_start | output | 1 | Transmit start pulse |
| tx_len | output | 16 | Transmit length after padding and limit |
| tx_ptr | output | 32 | Buffer address of the current transmit descriptor |
| tx_done | input | 1 | Transmit finished |
| rx_ready | output | 1 | Receive accepted |
| rx_req | input | 1 | Received frame strobe |
| rx_len | input | 16 | Received frame length |
| rx_miss | input | 1 | Address filter missed |
| rx_ptr | output | 32 | Buffer address of the current receive descriptor |
| ev_txb | output | 1 | Transmit-done event |
| ev_rxb | output | 1 | Receive-done event |
| ev_busy | output | 1 | Receive-dropped event |

## Verification
The bench builds the block with NDESC set to 16, which puts the reset boundary at 8. This makes the wrap at the last receive descriptor reachable in a few frames. The bench moves the boundary to 2, 0, 10 and 14 so that it can exercise the transmit wrap at the boundary, the start block at a zero boundary and the receive index reload. The default frame-length limits of 64 and 1536 are kept, so both the padding case and the truncation case occur.

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl #(
  parameter int NDESC = 128,
  parameter logic [31:0] PKTLEN_RST = 32'h0040_0600
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_sel,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic                         dt_we,
  input  logic [$clog2(NDESC):0]       dt_addr,
  input  logic [31:0]                  dt_wdata,
  output logic [31:0]                  dt_rdata,
  output logic                         tx_start,
  output logic [15:0]                  tx_len,
  output logic [31:0]                  tx_ptr,
  input  logic                         tx_done,
  output logic                         rx_ready,
  input  logic                         rx_req,
  input  logic [15:0]                  rx_len,
  input  logic                         rx_miss,
  output logic [31:0]                  rx_ptr,
  output logic                         ev_txb,
  output logic                         ev_rxb,
  output logic                         ev_busy
);
  localparam int IW = $clog2(NDESC);
  localparam int B_RDY = 15, B_IRQ = 14, B_WRAP = 13, B_PAD = 12, B_MISS = 7;
  localparam logic [31:0] CLR_MASK = 32'h0000_81FF;

  logic [31:0]   lf  [NDESC];
  logic [31:0]   ptr [NDESC];
  logic [2:0]    mode;
  logic [IW-1:0] bnd, tx_idx, rx_idx;
  logic [31:0]   pktlen;
  logic          tx_busy;

  wire rx_en = mode[0];
  wire tx_en = mode[1];
  wire huge  = mode[2];

  wire [IW-1:0] dt_idx = dt_addr[IW:1];
  wire          dt_odd = dt_addr[0];

  wire [31:0] tx_lf = lf[tx_idx];
  wire [31:0] rx_lf = lf[rx_idx];

  wire [15:0] min_fl  = pktlen[31:16];
  wire [15:0] max_fl  = pktlen[15:0];
  wire [15:0] raw_len = tx_lf[31:16];
  wire [15:0] pad_len = (tx_lf[B_PAD] && raw_len < min_fl) ? min_fl : raw_len;

  assign tx_len   = (!huge && pad_len > max_fl) ? max_fl : pad_len;
  assign tx_start = tx_en && !tx_busy && bnd != '0 && tx_lf[B_RDY] && raw_len > 16'd4;
  assign tx_ptr   = ptr[tx_idx];
  assign rx_ptr   = ptr[rx_idx];
  assign rx_ready = rx_en;
  assign dt_rdata = dt_odd ? ptr[dt_idx] : lf[dt_idx];

  wire tx_fin  = tx_busy && tx_done;
  wire rx_take = rx_en && rx_req;
  wire rx_fill = rx_take && rx_lf[B_RDY];

  wire [IW:0]   tx_inc = {1'b0, tx_idx} + (IW+1)'(1);
  wire [IW-1:0] tx_nxt = (tx_lf[B_WRAP] || tx_inc >= {1'b0, bnd}) ? '0 : tx_inc[IW-1:0];
  wire [IW-1:0] rx_nxt = (rx_lf[B_WRAP] || rx_idx == IW'(NDESC-1)) ? bnd : rx_idx + IW'(1);

  wire [31:0] tx_clr = tx_lf & ~CLR_MASK;
  wire [31:0] rx_upd = {rx_len, rx_lf[15:0] & ~CLR_MASK[15:0]} | (rx_miss ? (32'd1 << B_MISS) : 32'd0);

  wire       mode_we  = reg_we && reg_sel == 2'd0;
  wire [2:0] mode_set = reg_wdata[2:0] & ~mode & {3{mode_we}};

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {29'd0, mode};
      2'd1:    reg_rdata = 32'(bnd);
      2'd2:    reg_rdata = pktlen;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      bnd     <= IW'(NDESC/2);
      pktlen  <= PKTLEN_RST;
      tx_idx  <= '0;
      rx_idx  <= IW'(NDESC/2);
      tx_busy <= 1'b0;
      ev_txb  <= 1'b0;
      ev_rxb  <= 1'b0;
      ev_busy <= 1'b0;
    end else begin
      if (mode_we) mode <= reg_wdata[2:0];
      if (reg_we && reg_sel == 2'd1 && reg_wdata < 32'(NDESC)) bnd <= reg_wdata[IW-1:0];
      if (reg_we && reg_sel == 2'd2) pktlen <= reg_wdata;

      if (mode_set[1])  tx_idx <= '0;
      else if (tx_fin)  tx_idx <= tx_nxt;

      if (tx_start)     tx_busy <= 1'b1;
      else if (tx_done) tx_busy <= 1'b0;

      if (mode_set[0])  rx_idx <= bnd;
      else if (rx_fill) rx_idx <= rx_nxt;

      ev_txb  <= tx_fin && tx_lf[B_IRQ];
      ev_rxb  <= rx_fill && rx_lf[B_IRQ];
      ev_busy <= rx_take && !rx_lf[B_RDY];
    end
  end

  always_ff @(posedge clk) begin
    if (dt_we) begin
      if (dt_odd) ptr[dt_idx] <= dt_wdata;
      else        lf[dt_idx]  <= dt_wdata;
    end
    if (tx_fin)  lf[tx_idx] <= tx_clr;
    if (rx_fill) lf[rx_idx] <= rx_upd;
  end
endmodule

module bd_ring_ctrl_chk #(
  parameter int NDESC = 128
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [1:0]                 reg_sel,
  input logic [31:0]                reg_wdata,
  input logic [2:0]                 mode,
  input logic [$clog2(NDESC)-1:0]   bnd,
  input logic [$clog2(NDESC)-1:0]   tx_idx,
  input logic [$clog2(NDESC)-1:0]   rx_idx,
  input logic [31:0]                tx_lf,
  input logic                       tx_start,
  input logic                       tx_done,
  input logic                       rx_req,
  input logic                       ev_txb,
  input logic                       ev_rxb,
  input logic                       ev_busy
);
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  p_start_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_lf[15] && mode[1] && bnd != '0));
  p_bnd_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1 && reg_wdata >= 32'(NDESC)) |=> $stable(bnd));
  p_rxen_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[0]) |-> rx_idx == $past(bnd));
  p_txen_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[1]) |-> tx_idx == '0);
  p_txb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txb |-> $past(tx_done));
  p_rxb_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxb |-> ($past(rx_req) && $past(mode[0])));
  p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |-> ($past(rx_req) && !ev_rxb));
  p_rx_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] |=> (!ev_rxb && !ev_busy));
endmodule

bind bd_ring_ctrl bd_ring_ctrl_chk #(.NDESC(NDESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .mode(mode), .bnd(bnd), .tx_idx(tx_idx), .rx_idx(rx_idx), .tx_lf(tx_lf),
  .tx_start(tx_start), .tx_done(tx_done), .rx_req(rx_req),
  .ev_txb(ev_txb), .ev_rxb(ev_rxb), .ev_busy(ev_busy)
);

// File: tb/bd_ring_ctrl_test.sv
module bd_ring_ctrl_test;
  localparam int CLK_P = 10;
  localparam int ND = 16;
  localparam int AW = $clog2(ND) + 1;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, dt_we = 0, tx_done = 0, rx_req = 0, rx_miss = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, dt_wdata = 0;
  logic [AW-1:0] dt_addr = 0;
  logic [15:0] rx_len = 0;
  logic [31:0] reg_rdata, dt_rdata, tx_ptr, rx_ptr;
  logic [15:0] tx_len;
  logic tx_start, rx_ready, ev_txb, ev_rxb, ev_busy;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  bd_ring_ctrl #(.NDESC(ND)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dt_we(dt_we), .dt_addr(dt_addr), .dt_wdata(dt_wdata),
    .dt_rdata(dt_rdata), .tx_start(tx_start), .tx_len(tx_len), .tx_ptr(tx_ptr),
    .tx_done(tx_done), .rx_ready(rx_ready), .rx_req(rx_req), .rx_len(rx_len),
    .rx_miss(rx_miss), .rx_ptr(rx_ptr), .ev_txb(ev_txb), .ev_rxb(ev_rxb), .ev_busy(ev_busy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d; step(); reg_we = 0;
  endtask

  task automatic rreg(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wdt(input int i, input bit odd, input logic [31:0] d);
    dt_we = 1; dt_addr = AW'(i*2 + int'(odd)); dt_wdata = d; step(); dt_we = 0;
  endtask

  task automatic rlf(input int i, output logic [31:0] v);
    dt_addr = AW'(i*2); #1; v = dt_rdata;
  endtask

  task automatic done_pulse(); tx_done = 1; step(); tx_done = 0; endtask

  task automatic rx_pulse(input logic [15:0] len, input logic miss);
    rx_req = 1; rx_len = len; rx_miss = miss; step(); rx_req = 0; rx_miss = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rreg(2'd1, v); chk("R1 boundary", v, 32'd8);
    rreg(2'd2, v); chk("R1 pktlen", v, 32'h0040_0600);
    rreg(2'd0, v); chk("R1 mode", v, 32'd0);
    chk("R1 tx index", tx_ptr, 32'h1000);
    chk("R1 rx index", rx_ptr, 32'h1008);
    chk("R1 quiet", {28'd0, tx_start, ev_txb, ev_rxb, ev_busy}, 32'd0);
  endtask

  task automatic t_bnd();
    logic [31:0] v;
    wreg(2'd1, 32'd16); rreg(2'd1, v); chk("R2 ignore 16", v, 32'd8);
    wreg(2'd1, 32'h8000_0003); rreg(2'd1, v); chk("R2 ignore large", v, 32'd8);
    wreg(2'd1, 32'd12); rreg(2'd1, v); chk("R2 accept 12", v, 32'd12);
    wreg(2'd1, 32'd8);
  endtask

  task automatic t_tx_basic();
    logic [31:0] v;
    wreg(2'd0, 32'd2);
    chk("R4 no start on empty", {31'd0, tx_start}, 32'd0);
    wdt(0, 0, (32'd100 << 16) | 32'hC1F3);
    chk("R4 start", {31'd0, tx_start}, 32'd1);
    chk("R5 plain len", {16'd0, tx_len}, 32'd100);
    chk("R4 start ptr", tx_ptr, 32'h1000);
    step();
    chk("R4 single pulse", {31'd0, tx_start}, 32'd0);
    done_pulse();
    chk("R8 txb pulse", {31'd0, ev_txb}, 32'd1);
    rlf(0, v); chk("R6 status cleared", v, 32'h0064_4000);
    chk("R7 increment", tx_ptr, 32'h1001);
    step();
    chk("R8 txb one cycle", {31'd0, ev_txb}, 32'd0);
  endtask

  task automatic t_tx_len();
    wdt(1, 0, (32'd4 << 16) | 32'h8000);
    chk("R4 len 4 blocked", {31'd0, tx_start}, 32'd0);
    wdt(1, 0, (32'd20 << 16) | 32'h9000);
    chk("R4 start padded", {31'd0, tx_start}, 32'd1);
    chk("R5 padded to min", {16'd0, tx_len}, 32'd64);
    step(); done_pulse();
    chk("R8 no irq no txb", {31'd0, ev_txb}, 32'd0);
    chk("R7 to 2", tx_ptr, 32'h1002);
    wdt(2, 0, (32'd2000 << 16) | 32'h8000);
    chk("R5 cut to max", {16'd0, tx_len}, 32'd1536);
    wreg(2'd0, 32'd6);
    chk("R5 huge keeps len", {16'd0, tx_len}, 32'd2000);
    done_pulse();
    chk("R7 to 3", tx_ptr, 32'h1003);
    wreg(2'd0, 32'd2);
  endtask

  task automatic t_tx_wrap();
    wdt(3, 0, (32'd10 << 16) | 32'hA000);
    step(); done_pulse();
    chk("R7 wrap bit", tx_ptr, 32'h1000);
    wreg(2'd1, 32'd2);
    wdt(0, 0, (32'd10 << 16) | 32'h8000); step(); done_pulse();
    chk("R7 inc below N", tx_ptr, 32'h1001);
    wdt(1, 0, (32'd10 << 16) | 32'h8000); step(); done_pulse();
    chk("R7 wrap at N", tx_ptr, 32'h1000);
    wreg(2'd1, 32'd0);
    wdt(0, 0, (32'd10 << 16) | 32'h8000);
    chk("R4 zero boundary blocks", {31'd0, tx_start}, 32'd0);
    wreg(2'd1, 32'd8);
    chk("R4 start after boundary", {31'd0, tx_start}, 32'd1);
    step(); done_pulse();
    chk("R7 to 1", tx_ptr, 32'h1001);
  endtask

  task automatic t_tx_en();
    done_pulse();
    chk("R13 stray done no event", {31'd0, ev_txb}, 32'd0);
    chk("R13 stray done no move", tx_ptr, 32'h1001);
    wreg(2'd0, 32'd0); wreg(2'd0, 32'd2);
    chk("R3 tx enable resets", tx_ptr, 32'h1000);
    chk("R4 cleared desc idle", {31'd0, tx_start}, 32'd0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    chk("R13 rx not ready", {31'd0, rx_ready}, 32'd0);
    wdt(8, 0, 32'hC000);
    rx_pulse(16'd60, 1'b1);
    chk("R13 rx off no event", {30'd0, ev_rxb, ev_busy}, 32'd0);
    rlf(8, v); chk("R13 rx off desc kept", v, 32'h0000_C000);
    wreg(2'd1, 32'd10); wreg(2'd0, 32'd3);
    chk("R3 rx enable loads N", rx_ptr, 32'h100A);
    wdt(10, 0, 32'h0000_4000);
    rx_pulse(16'd60, 1'b0);
    chk("R9 busy event", {30'd0, ev_rxb, ev_busy}, 32'd1);
    rlf(10, v); chk("R9 desc kept", v, 32'h0000_4000);
    chk("R9 index kept", rx_ptr, 32'h100A);
    wdt(10, 0, 32'h0000_C1FF);
    rx_pulse(16'd60, 1'b1);
    chk("R12 rxb event", {30'd0, ev_rxb, ev_busy}, 32'd2);
    rlf(10, v); chk("R10 status with miss", v, 32'h003C_4080);
    chk("R11 increment", rx_ptr, 32'h100B);
    wdt(11, 0, 32'h0000_A080);
    rx_pulse(16'd70, 1'b0);
    chk("R12 no irq no rxb", {31'd0, ev_rxb}, 32'd0);
    rlf(11, v); chk("R10 status no miss", v, 32'h0046_2000);
    chk("R11 wrap bit", rx_ptr, 32'h100A);
    wreg(2'd1, 32'd14); wreg(2'd0, 32'd2); wreg(2'd0, 32'd3);
    chk("R3 rx reload 14", rx_ptr, 32'h100E);
    wdt(14, 0, 32'h8000); rx_pulse(16'd5, 1'b0);
    chk("R11 to last", rx_ptr, 32'h100F);
    wdt(15, 0, 32'h8000); rx_pulse(16'd5, 1'b0);
    chk("R11 last returns to N", rx_ptr, 32'h100E);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    for (int i = 0; i < ND; i++) begin
      wdt(i, 1, 32'h1000 + 32'(i));
      wdt(i, 0, 32'd0);
    end
    t_reset();
    t_bnd();
    t_tx_basic();
    t_tx_len();
    t_tx_wrap();
    t_tx_en();
    t_rx();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule